// File: doc/BRIEF.md
# Endpoint STALL Handshake Control

This block holds, for each of a set of device endpoints, whether the device must answer host tokens with a STALL handshake. It also records that a STALL has actually gone out. Firmware first picks an endpoint through a select register. It then writes a control word for that endpoint: a stall request, a stall-sent flag that it can only clear, and an interrupt enable. The packet engine presents each incoming token to the block. In the same cycle, the block tells the engine whether to respond with STALL.

Two rules come from the transfer types. An isochronous endpoint never stalls. A stalled control endpoint still takes a SETUP token, and a validated SETUP on a control endpoint drops the request in hardware. A stall request made while the endpoint still has unfinished transfer status (setup received, transmit ready, transmit complete, or either OUT bank received) is held as pending with an error status. It takes effect once all five status bits read zero.

Top module: `ep_stall_ctrl`

## Requirements
- R1: After reset, every endpoint's control word reads 0, the select register reads 0, and `stall_o` and `irq_o` are low.
- R2: A control write with bit 0 set, to a selected non-isochronous endpoint with all five status bits clear, sets that endpoint's stall request. The request reads back in `fw_ctl_q` bit 0 after the write's clock edge.
- R3: While an endpoint's request is set, `stall_o` is high in the same cycle as every non-SETUP token to that endpoint, including repeated tokens. It is low for tokens to other endpoints.
- R4: Endpoint type encoding per 2-bit field is 0 control, 1 isochronous, 2 bulk, 3 interrupt. A stall request written to an isochronous endpoint is ignored: the request bit and the error bit stay 0, and no STALL is issued.
- R5: A stall request written while any of the endpoint's status bits is set leaves the request at 0 and raises the error bit (`fw_ctl_q` bit 2). One clock edge after all five status bits read zero, the request becomes 1 and the error bit clears.
- R6: A stall-sent report from the packet engine sets that endpoint's sent bit (`fw_ctl_q` bit 1) at the next edge. The bit holds until firmware clears it. `irq_o` is high while any endpoint has both its sent bit and its interrupt enable (`fw_ctl_q` bit 3) set.
- R7: A SETUP token to a stalled control endpoint gets no STALL. A validated SETUP on a control endpoint clears its request at the next edge. A validated SETUP on any other type leaves the request set.
- R8: A control write with bit 0 clear drops both the request and any pending request. A write with bit 1 clear clears the sent bit, while bit 1 set has no effect on it. Bit 2 of the write sets the interrupt enable.
- R9: `fw_sel_q` returns the last value written to the select register, and `fw_ctl_q` shows the selected endpoint's bits.
- R10: In the same cycle, a hardware SETUP clear beats a firmware stall request, and a stall-sent report beats a firmware clear of the sent bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ep_type_i | input | 2*NUM_EP | Per-endpoint transfer type, 2 bits each |
| ep_flags_i | input | 5*NUM_EP | Per-endpoint transfer status bits, 5 bits each |
| fw_sel_we | input | 1 | Endpoint select register write strobe |
| fw_sel_d | input | EPW | Endpoint select write data |
| fw_sel_q | output | EPW | Endpoint select readback |
| fw_ctl_we | input | 1 | Control word write strobe for the selected endpoint |
| fw_ctl_d | input | 3 | Write data: bit0 request, bit1 sent keep, bit2 irq enable |
| fw_ctl_q | output | 4 | Selected endpoint: bit0 request, bit1 sent, bit2 error, bit3 irq enable |
| pe_tok_valid | input | 1 | Host token present |
| pe_tok_ep | input | EPW | Token endpoint number |
| pe_tok_setup | input | 1 | Token is SETUP |
| pe_setup_ok | input | 1 | Valid SETUP PID accepted |
| pe_setup_ep | input | EPW | Endpoint of the accepted SETUP |
| pe_stall_done | input | 1 | A STALL handshake was sent |
| pe_stall_ep | input | EPW | Endpoint the STALL was sent on |
| stall_o | output | 1 | Answer the present token with STALL |
| irq_o | output | 1 | Stall-sent interrupt |

## Verification
`stall_o` is a same-cycle decision. The bench presents a token after a falling edge and samples one nanosecond later, before the next rising edge. Register writes, stall-sent reports, SETUP clears and pending releases take effect at exactly one rising edge. Each is driven for one cycle starting at a falling edge, and the readback is sampled at the following falling edge. For the R10 races, both events are driven in the same cycle so that the priority is what decides the result.

// File: rtl/ep_stall_ctrl.sv
module ep_stall_ctrl #(
  parameter int NUM_EP = 8,
  localparam int EPW = $clog2(NUM_EP)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*NUM_EP-1:0] ep_type_i,
  input  logic [5*NUM_EP-1:0] ep_flags_i,
  input  logic                fw_sel_we,
  input  logic [EPW-1:0]      fw_sel_d,
  output logic [EPW-1:0]      fw_sel_q,
  input  logic                fw_ctl_we,
  input  logic [2:0]          fw_ctl_d,
  output logic [3:0]          fw_ctl_q,
  input  logic                pe_tok_valid,
  input  logic [EPW-1:0]      pe_tok_ep,
  input  logic                pe_tok_setup,
  input  logic                pe_setup_ok,
  input  logic [EPW-1:0]      pe_setup_ep,
  input  logic                pe_stall_done,
  input  logic [EPW-1:0]      pe_stall_ep,
  output logic                stall_o,
  output logic                irq_o
);
  localparam logic [1:0] T_CTRL = 2'd0;
  localparam logic [1:0] T_ISO  = 2'd1;

  logic [EPW-1:0]    sel_q;
  logic [NUM_EP-1:0] req_q, pend_q, sent_q, ie_q;
  logic [NUM_EP-1:0] req_n, pend_n, sent_n, ie_n;

  always_comb begin
    req_n = req_q; pend_n = pend_q; sent_n = sent_q; ie_n = ie_q;
    for (int i = 0; i < NUM_EP; i++) begin
      if (fw_ctl_we && sel_q == EPW'(i)) begin
        ie_n[i] = fw_ctl_d[2];
        if (!fw_ctl_d[1]) sent_n[i] = 1'b0;
        if (!fw_ctl_d[0]) begin
          req_n[i] = 1'b0; pend_n[i] = 1'b0;
        end else if (ep_type_i[2*i +: 2] != T_ISO && !req_q[i]) begin
          if (|ep_flags_i[5*i +: 5]) pend_n[i] = 1'b1;
          else begin req_n[i] = 1'b1; pend_n[i] = 1'b0; end
        end
      end else if (pend_q[i] && !(|ep_flags_i[5*i +: 5])) begin
        req_n[i] = 1'b1; pend_n[i] = 1'b0;
      end
      if (pe_setup_ok && pe_setup_ep == EPW'(i) && ep_type_i[2*i +: 2] == T_CTRL) begin
        req_n[i] = 1'b0; pend_n[i] = 1'b0;
      end
      if (pe_stall_done && pe_stall_ep == EPW'(i)) sent_n[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0; req_q <= '0; pend_q <= '0; sent_q <= '0; ie_q <= '0;
    end else begin
      if (fw_sel_we) sel_q <= fw_sel_d;
      req_q <= req_n; pend_q <= pend_n; sent_q <= sent_n; ie_q <= ie_n;
    end
  end

  assign fw_sel_q = sel_q;
  assign fw_ctl_q = {ie_q[sel_q], pend_q[sel_q], sent_q[sel_q], req_q[sel_q]};
  assign stall_o  = pe_tok_valid && !pe_tok_setup && req_q[pe_tok_ep] &&
                    ep_type_i[2*pe_tok_ep +: 2] != T_ISO;
  assign irq_o    = |(sent_q & ie_q);

  a_r7_setup_clears_req: assert property (@(posedge clk) disable iff (!rst_n)
    pe_setup_ok && ep_type_i[2*pe_setup_ep +: 2] == T_CTRL |=> !req_q[$past(pe_setup_ep)]);
  a_r6_sent_after_report: assert property (@(posedge clk) disable iff (!rst_n)
    pe_stall_done |=> sent_q[$past(pe_stall_ep)]);
  a_r5_pending_excludes_req: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & req_q) == '0);
  a_r4_iso_write_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    fw_ctl_we && ep_type_i[2*sel_q +: 2] == T_ISO && !req_q[sel_q] && !pend_q[sel_q]
    |=> !req_q[$past(sel_q)]);
  a_r6_irq_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(pe_stall_done || fw_ctl_we));
endmodule

// File: tb/test_ep_stall_ctrl.sv
module test_ep_stall_ctrl;
  localparam int NUM_EP = 8;
  localparam int EPW = 3;

  logic clk = 0, rst_n = 0;
  logic [2*NUM_EP-1:0] ep_type_i;
  logic [5*NUM_EP-1:0] ep_flags_i = '0;
  logic fw_sel_we = 0, fw_ctl_we = 0;
  logic [EPW-1:0] fw_sel_d = '0, fw_sel_q;
  logic [2:0] fw_ctl_d = '0;
  logic [3:0] fw_ctl_q;
  logic pe_tok_valid = 0, pe_tok_setup = 0, pe_setup_ok = 0, pe_stall_done = 0;
  logic [EPW-1:0] pe_tok_ep = '0, pe_setup_ep = '0, pe_stall_ep = '0;
  logic stall_o, irq_o;
  int checks = 0, errors = 0;

  // ep0 ctrl, ep1 iso, ep2 bulk, ep3 intr, ep4 ctrl, ep5-7 bulk
  assign ep_type_i = {2'd2, 2'd2, 2'd2, 2'd0, 2'd3, 2'd2, 2'd1, 2'd0};

  always #2.5 clk = ~clk;

  ep_stall_ctrl #(.NUM_EP(NUM_EP)) i_ep_stall_ctrl (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sel(logic [EPW-1:0] ep);
    @(negedge clk); fw_sel_we = 1; fw_sel_d = ep;
    @(negedge clk); fw_sel_we = 0;
  endtask

  task automatic ctl(logic [2:0] d);
    @(negedge clk); fw_ctl_we = 1; fw_ctl_d = d;
    @(negedge clk); fw_ctl_we = 0;
  endtask

  task automatic tok(logic [EPW-1:0] ep, logic setup, logic exp, string tag);
    @(negedge clk); pe_tok_valid = 1; pe_tok_ep = ep; pe_tok_setup = setup;
    #1 chk(tag, stall_o, exp);
    @(negedge clk); pe_tok_valid = 0; pe_tok_setup = 0;
  endtask

  task automatic t_reset;
    chk("R1 stall", stall_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 ctl", fw_ctl_q, 0);
    chk("R1 sel", fw_sel_q, 0);
  endtask

  task automatic t_request;
    sel(2); chk("R9 sel", fw_sel_q, 2);
    ctl(3'b001); chk("R2 req", fw_ctl_q, 4'b0001);
    tok(2, 0, 1, "R3 first token");
    tok(2, 0, 1, "R3 repeat token");
    tok(3, 0, 0, "R3 other ep");
    sel(3); chk("R9 view ep3", fw_ctl_q, 0);
  endtask

  task automatic t_iso;
    sel(1); ctl(3'b001);
    chk("R4 iso ctl", fw_ctl_q, 0);
    tok(1, 0, 0, "R4 iso token");
  endtask

  task automatic t_pending;
    sel(3);
    @(negedge clk); ep_flags_i[5*3+2] = 1;
    ctl(3'b001); chk("R5 pending err", fw_ctl_q, 4'b0100);
    tok(3, 0, 0, "R5 no stall while pending");
    @(negedge clk); ep_flags_i = '0;
    @(negedge clk); chk("R5 released", fw_ctl_q, 4'b0001);
  endtask

  task automatic t_sent;
    sel(2); ctl(3'b111);
    chk("R8 keep sent/ie", fw_ctl_q, 4'b1001);
    @(negedge clk); pe_stall_done = 1; pe_stall_ep = 2;
    @(negedge clk); pe_stall_done = 0;
    chk("R6 sent set", fw_ctl_q, 4'b1011);
    chk("R6 irq", irq_o, 1);
    repeat (3) @(negedge clk);
    chk("R6 sent held", fw_ctl_q, 4'b1011);
    ctl(3'b100);
    chk("R8 cleared", fw_ctl_q, 4'b1000);
    chk("R8 irq low", irq_o, 0);
    @(negedge clk); pe_stall_done = 1; pe_stall_ep = 3;
    @(negedge clk); pe_stall_done = 0;
    chk("R6 no ie no irq", irq_o, 0);
    sel(3); chk("R6 ep3 sent", fw_ctl_q, 4'b0011);
    ctl(3'b000); chk("R8 ep3 clear", fw_ctl_q, 0);
  endtask

  task automatic t_setup;
    sel(0); ctl(3'b001);
    tok(0, 1, 0, "R7 setup not stalled");
    tok(0, 0, 1, "R7 data stalled");
    @(negedge clk); pe_setup_ok = 1; pe_setup_ep = 0;
    @(negedge clk); pe_setup_ok = 0;
    chk("R7 ctrl auto clear", fw_ctl_q, 0);
    sel(2); ctl(3'b001);
    @(negedge clk); pe_setup_ok = 1; pe_setup_ep = 2;
    @(negedge clk); pe_setup_ok = 0;
    chk("R7 bulk keeps req", fw_ctl_q, 4'b0001);
  endtask

  task automatic t_race;
    sel(4);
    @(negedge clk); fw_ctl_we = 1; fw_ctl_d = 3'b001; pe_setup_ok = 1; pe_setup_ep = 4;
    @(negedge clk); fw_ctl_we = 0; pe_setup_ok = 0;
    chk("R10 setup beats fw", fw_ctl_q, 0);
    sel(2);
    @(negedge clk); fw_ctl_we = 1; fw_ctl_d = 3'b000; pe_stall_done = 1; pe_stall_ep = 2;
    @(negedge clk); fw_ctl_we = 0; pe_stall_done = 0;
    chk("R10 sent beats clear", fw_ctl_q, 4'b0010);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_request; t_iso; t_pending; t_sent; t_setup; t_race;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule